// File: doc/BRIEF.md
# DSP Register Host-Access Port

This block lets a host processor reach the general-purpose register file of a signal processor through a small word-addressed window. The register file has 192 entries of 24 bits each. The host cannot address an entry directly. It first builds a 24-bit transfer latch one byte at a time. It then writes a register index to one of two command offsets. A read select copies the indexed register into the latch. A write select stores the latch into the indexed register. After a read select, the host reads the latch back one byte at a time.

The register file is held inside the block so that its contents can be observed through the window. Two further command offsets stand for instruction-memory writes. They are accepted but do nothing. Every other offset in the 512-word window acts as a plain scratch location that returns the last word written to it. Two offsets are exceptions: one always reads zero and one always reads a fixed identification value.

Top module: `dsp_reg_port`

## Requirements
- R1: A synchronous active-low reset clears the latch, every register entry and every scratch location, so all of them read as zero afterwards.
- R2: A write to offset 0x00, 0x01 or 0x02 loads latch bits 23:16, 15:8 or 7:0 respectively from data bits 7:0. The other two latch bytes are left unchanged.
- R3: A read of offset 0x00, 0x01 or 0x02 returns the high, middle or low latch byte in data bits 7:0, with bits 15:8 zero. A read of offset 0x03 returns zero.
- R4: A write to offset 0x80 with a 16-bit data value below 192 copies the register at that index into the latch. The new latch value is readable in the cycle after the write strobe.
- R5: A write to offset 0xA0 with a 16-bit data value below 192 stores the latch into the register at that index. The store completes one clock after the strobe, so a read select issued in the very next cycle returns the new value.
- R6: A read select or write select whose 16-bit data value is 192 or more (for example 0x00C0, 0x00C5 or 0x0105) changes neither the latch nor any register.
- R7: Writes to offset 0xC0 or 0xE0 change neither the latch nor any register.
- R8: Offset 0x12 always reads 0x0000 and offset 0x16 always reads 0x0027, whatever was written to them.
- R9: Every offset other than 0x00 to 0x03, 0x12 and 0x16 reads back the last full 16-bit word written to it, command offsets included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| host_we | input | 1 | Write strobe, one word per cycle |
| host_addr | input | 9 | Word offset in the window, used for both writes and reads |
| host_wdata | input | 16 | Write data; low byte for latch writes, full word as the index for selects |
| host_rdata | output | 16 | Read data for `host_addr`, combinational |

## Verification
A corrupted latch byte shows up on the very next read of that byte. A register entry that was stored wrongly, or was disturbed by an out-of-range index or an instruction write, stays hidden until the host issues a read select for that index and then reads the latch. So the fault appears two transactions after it happens. For this reason every ignore case in the bench is followed by a read select of a known entry, or a read-back of the latch, before the next stimulus. The store-then-select sequence is also run in adjacent cycles, which exposes a write path that is one clock too slow.

// File: rtl/dsp_port_pkg.sv
// Package: shared sizes and window offsets for the DSP register host port.
// Assumes a 9-bit word-offset window and a 16-bit host data bus.
package dsp_port_pkg;
    localparam int unsigned HOST_AW   = 9;
    localparam int unsigned HOST_DW   = 16;
    localparam int unsigned REG_W     = 24;
    localparam int unsigned REG_DEPTH = 192;

    localparam logic [HOST_AW-1:0] OFS_RD_SEL   = 9'h080;
    localparam logic [HOST_AW-1:0] OFS_WR_SEL   = 9'h0A0;
    localparam logic [HOST_AW-1:0] OFS_INSTR    = 9'h0C0;
    localparam logic [HOST_AW-1:0] OFS_BOTH     = 9'h0E0;
    localparam logic [HOST_AW-1:0] OFS_ZERO     = 9'h012;
    localparam logic [HOST_AW-1:0] OFS_IDENT    = 9'h016;
    localparam logic [HOST_DW-1:0] IDENT_VALUE  = 16'h0027;
endpackage

// File: rtl/port_cmd_decode.sv
// Module: port_cmd_decode
// Turns one host write into latch byte strobes and register select commands.
// Assumes the latch bytes sit at offsets 0..NB-1, most significant byte first.
// Select indices are the full data word; out-of-range values produce no command.
module port_cmd_decode
    import dsp_port_pkg::*;
#(
    parameter int unsigned AW    = HOST_AW,
    parameter int unsigned DW    = HOST_DW,
    parameter int unsigned NB    = REG_W / 8,
    parameter int unsigned DEPTH = REG_DEPTH,
    parameter int unsigned IDXW  = $clog2(DEPTH)
) (
    input  logic            host_we,
    input  logic [AW-1:0]   host_addr,
    input  logic [DW-1:0]   host_wdata,
    output logic [NB-1:0]   byte_we,
    output logic            load_en,
    output logic            store_en,
    output logic [IDXW-1:0] sel_idx
);
    localparam logic [DW-1:0] IDX_LIMIT = DW'(DEPTH);

    logic idx_ok;

    // Purpose: range check on the select index.
    assign idx_ok  = host_wdata < IDX_LIMIT;
    assign sel_idx = host_wdata[IDXW-1:0];

    // Purpose: one strobe per latch byte, highest byte at the lowest offset.
    for (genvar k = 0; k < NB; k++) begin : g_byte
        assign byte_we[NB-1-k] = host_we && (host_addr == AW'(k));
    end

    // Purpose: select commands, gated by the index range.
    assign load_en  = host_we && (host_addr == OFS_RD_SEL) && idx_ok;
    assign store_en = host_we && (host_addr == OFS_WR_SEL) && idx_ok;
endmodule

// File: rtl/xfer_latch.sv
// Module: xfer_latch
// Transfer latch, written one byte at a time by the host or loaded whole
// from the register file. Assumes at most one of the two happens per cycle;
// a whole-word load wins if both are ever asserted.
module xfer_latch #(
    parameter int unsigned W  = 24,
    parameter int unsigned NB = W / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] byte_we,
    input  logic [7:0]    byte_val,
    input  logic          load_en,
    input  logic [W-1:0]  load_val,
    output logic [W-1:0]  latch_q
);
    // Purpose: one register per byte lane, each with its own write strobe.
    for (genvar b = 0; b < NB; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                latch_q[b*8 +: 8] <= '0;
            else if (load_en)
                latch_q[b*8 +: 8] <= load_val[b*8 +: 8];
            else if (byte_we[b])
                latch_q[b*8 +: 8] <= byte_val;
        end

        localparam logic [W-1:0] LANE_MASK = W'({8{1'b1}}) << (b*8);

        // R2: a byte write leaves the other lanes alone
        p_lane_isolated_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (byte_we[b] && !load_en) |=>
                ((latch_q & ~LANE_MASK) == ($past(latch_q) & ~LANE_MASK)));
    end

    // R2: the decoder never strobes two lanes at once
    p_single_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(byte_we));

    // R4: a load lands whole on the next cycle
    p_load_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (latch_q == $past(load_val)));

    // R6: without a strobe or a load the latch holds
    p_latch_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && (byte_we == '0)) |=> $stable(latch_q));
endmodule

// File: rtl/gpr_file.sv
// Module: gpr_file
// General-purpose register file with one write port and one combinational
// read port. Assumes the write index was range-checked upstream; an
// out-of-range read index returns zero.
module gpr_file #(
    parameter int unsigned DEPTH = 192,
    parameter int unsigned W     = 24,
    parameter int unsigned IDXW  = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [W-1:0]    wr_val,
    input  logic [IDXW-1:0] rd_idx,
    output logic [W-1:0]    rd_val
);
    localparam logic [IDXW:0] LIMIT = (IDXW+1)'(DEPTH);

    logic [W-1:0] regs [DEPTH];

    // Purpose: clear on reset, otherwise store one entry per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (wr_en) begin
            regs[wr_idx] <= wr_val;
        end
    end

    // Purpose: guarded combinational read.
    always_comb begin
        if ({1'b0, rd_idx} < LIMIT) rd_val = regs[rd_idx];
        else                        rd_val = '0;
    end

    // R6: no store may target an index beyond the file
    p_store_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ({1'b0, wr_idx} < LIMIT));

    // R5: the stored value is present one clock after the strobe
    p_store_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (regs[$past(wr_idx)] == $past(wr_val)));
endmodule

// File: rtl/scratch_mirror.sv
// Module: scratch_mirror
// Word store shadowing every host write so that plain offsets read back
// what was last written. Cleared by reset; read is combinational.
module scratch_mirror #(
    parameter int unsigned AW = 9,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Purpose: clear on reset, otherwise capture each host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Purpose: combinational read at the host offset.
    assign rdata = mem[addr];

    // R9: a written word is held at its offset on the next cycle
    p_mirror_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(addr)] == $past(wdata)));
endmodule

// File: rtl/dsp_reg_port.sv
// Module: dsp_reg_port (top)
// Host window into a DSP register file through a byte-built transfer latch.
// Assumes one host access per cycle; reads are combinational on host_addr.
module dsp_reg_port
    import dsp_port_pkg::*;
#(
    parameter int unsigned AW    = HOST_AW,
    parameter int unsigned DW    = HOST_DW,
    parameter int unsigned RW    = REG_W,
    parameter int unsigned DEPTH = REG_DEPTH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [8:0]    host_addr,
    input  logic [15:0]   host_wdata,
    output logic [15:0]   host_rdata
);
    localparam int unsigned NB   = RW / 8;
    localparam int unsigned IDXW = $clog2(DEPTH);

    logic [NB-1:0]   byte_we;
    logic            load_en;
    logic            store_en;
    logic [IDXW-1:0] sel_idx;
    logic [RW-1:0]   latch_q;
    logic [RW-1:0]   reg_rd_val;
    logic [DW-1:0]   mirror_q;

    port_cmd_decode #(.AW(AW), .DW(DW), .NB(NB), .DEPTH(DEPTH), .IDXW(IDXW)) dec_i (
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .byte_we    (byte_we),
        .load_en    (load_en),
        .store_en   (store_en),
        .sel_idx    (sel_idx)
    );

    xfer_latch #(.W(RW), .NB(NB)) latch_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_we  (byte_we),
        .byte_val (host_wdata[7:0]),
        .load_en  (load_en),
        .load_val (reg_rd_val),
        .latch_q  (latch_q)
    );

    gpr_file #(.DEPTH(DEPTH), .W(RW), .IDXW(IDXW)) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (store_en),
        .wr_idx (sel_idx),
        .wr_val (latch_q),
        .rd_idx (sel_idx),
        .rd_val (reg_rd_val)
    );

    scratch_mirror #(.AW(AW), .DW(DW)) mirror_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (host_we),
        .addr  (host_addr),
        .wdata (host_wdata),
        .rdata (mirror_q)
    );

    // Purpose: read mux; latch bytes, the pad word and fixed offsets take priority.
    always_comb begin
        host_rdata = mirror_q;
        if (host_addr == OFS_ZERO)       host_rdata = '0;
        else if (host_addr == OFS_IDENT) host_rdata = IDENT_VALUE;
        else if (host_addr == AW'(NB))   host_rdata = '0;
        for (int k = 0; k < NB; k++) begin
            if (host_addr == AW'(k))
                host_rdata = {8'h00, latch_q[(NB-1-k)*8 +: 8]};
        end
    end

    // R7: instruction-write offsets never reach the latch or the file
    p_instr_inert_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && (host_addr == OFS_INSTR || host_addr == OFS_BOTH))
            |-> (!load_en && !store_en && byte_we == '0));

    // R6: an out-of-range select index raises no command
    p_oob_inert_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_wdata >= DW'(DEPTH)) |-> (!load_en && !store_en));
endmodule

// File: tb/dsp_reg_port_tb_top.sv
module dsp_reg_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [8:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dsp_reg_port dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    // Vector: {is_write, offset, data or expected, requirement number}
    localparam int NV = 34;
    localparam logic [29:0] TBL [NV] = '{
        {1'b1, 9'h000, 16'h12AB, 4'd2},  // R2 high byte
        {1'b1, 9'h001, 16'h00CD, 4'd2},
        {1'b1, 9'h002, 16'hFFEF, 4'd2},
        {1'b0, 9'h000, 16'h00AB, 4'd3},  // R3 byte reads
        {1'b0, 9'h001, 16'h00CD, 4'd3},
        {1'b0, 9'h002, 16'h00EF, 4'd3},
        {1'b0, 9'h003, 16'h0000, 4'd3},
        {1'b1, 9'h0A0, 16'h0005, 4'd5},  // R5 store ABCDEF at 5
        {1'b1, 9'h001, 16'h0011, 4'd2},  // R2 middle only
        {1'b0, 9'h000, 16'h00AB, 4'd2},
        {1'b0, 9'h001, 16'h0011, 4'd2},
        {1'b0, 9'h002, 16'h00EF, 4'd2},
        {1'b1, 9'h080, 16'h0005, 4'd4},  // R4 reload entry 5
        {1'b0, 9'h001, 16'h00CD, 4'd4},
        {1'b1, 9'h080, 16'h00C0, 4'd6},  // R6 first invalid index
        {1'b0, 9'h001, 16'h00CD, 4'd6},
        {1'b1, 9'h080, 16'h0105, 4'd6},  // R6 full-word index
        {1'b0, 9'h000, 16'h00AB, 4'd6},
        {1'b1, 9'h000, 16'h0077, 4'd7},
        {1'b1, 9'h0C0, 16'h0005, 4'd7},  // R7 instruction writes
        {1'b1, 9'h0E0, 16'h0005, 4'd7},
        {1'b0, 9'h000, 16'h0077, 4'd7},
        {1'b1, 9'h080, 16'h0005, 4'd7},
        {1'b0, 9'h000, 16'h00AB, 4'd7},
        {1'b1, 9'h012, 16'hBEEF, 4'd8},  // R8 fixed reads
        {1'b0, 9'h012, 16'h0000, 4'd8},
        {1'b1, 9'h016, 16'h1234, 4'd8},
        {1'b0, 9'h016, 16'h0027, 4'd8},
        {1'b1, 9'h155, 16'hA5A5, 4'd9},  // R9 scratch words
        {1'b0, 9'h155, 16'hA5A5, 4'd9},
        {1'b0, 9'h080, 16'h0005, 4'd9},
        {1'b0, 9'h0A0, 16'h0005, 4'd9},
        {1'b1, 9'h0A0, 16'h00C5, 4'd6},  // R6 invalid store index
        {1'b0, 9'h002, 16'h00EF, 4'd6}
    };

    // One write strobe; called at a falling edge, returns at the next one.
    task automatic wr(input logic [8:0] a, input logic [15:0] d);
        host_we    = 1'b1;
        host_addr  = a;
        host_wdata = d;
        @(negedge clk);
        host_we    = 1'b0;
    endtask

    task automatic chk(input logic [8:0] a, input logic [15:0] exp, input string req);
        host_addr = a;
        #1;
        checks++;
        if (host_rdata !== exp) begin
            errors++;
            $display("FAIL %s offset %h actual %h expected %h", req, a, host_rdata, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state of latch, scratch and register file
        chk(9'h000, 16'h0000, "R1");
        chk(9'h002, 16'h0000, "R1");
        chk(9'h1FF, 16'h0000, "R1");
        wr(9'h080, 16'h00BF);
        chk(9'h001, 16'h0000, "R1");

        for (int i = 0; i < NV; i++) begin
            if (TBL[i][29])
                wr(TBL[i][28:20], TBL[i][19:4]);
            else
                chk(TBL[i][28:20], TBL[i][19:4], $sformatf("R%0d", TBL[i][3:0]));
        end

        // R5: last entry of the file, store then reload
        wr(9'h000, 16'h0001);
        wr(9'h001, 16'h0002);
        wr(9'h002, 16'h0003);
        wr(9'h0A0, 16'h00BF);
        wr(9'h000, 16'h0000);
        wr(9'h080, 16'h00BF);
        chk(9'h000, 16'h0001, "R5");
        chk(9'h001, 16'h0002, "R5");
        chk(9'h002, 16'h0003, "R5");

        // R5: store then select in adjacent cycles
        wr(9'h000, 16'h005A);
        wr(9'h0A0, 16'h0007);
        wr(9'h080, 16'h0007);
        chk(9'h000, 16'h005A, "R5");

        // R1: reset mid-run clears file, latch and scratch
        do_reset();
        chk(9'h155, 16'h0000, "R1");
        chk(9'h000, 16'h0000, "R1");
        wr(9'h000, 16'h00FF);
        wr(9'h080, 16'h0005);
        chk(9'h000, 16'h0000, "R1");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule